// File: doc/BRIEF.md
# Next Program Counter Unit

This unit owns the program counter of a simple 32-bit processor and works out, every cycle, the address of the next instruction. A decoded flow class picks one of five outcomes: fall through to the next word, a conditional branch on equality or on inequality of two register operands, a region-relative absolute jump, the same jump with a return link, or an indirect jump to an address taken from a register.

Branch targets are measured from the already-incremented counter, with the signed 16-bit displacement counted in words. Absolute jump targets keep the top four bits of the current counter and take the rest from the 26-bit field, shifted two places left. When the jump carries a link, the unit asks for the return address (counter plus four) to be written into register 31. The counter moves only when the advance enable is high. A synchronous reset loads a start address that is set by a parameter.

Fetch, decode and register storage sit outside this block. The surrounding pipeline supplies the operands and the decoded class, and it performs the link write that this unit requests.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `START_ADDR` (default 0x0040_0000), and `link_we_o` and `taken_o` go low. Reset takes priority over `adv_en` and over every flow class.
- R2: At an edge where `adv_en` is low (and reset is low), the counter keeps its value and both `link_we_o` and `taken_o` are low in the following cycle.
- R3: Flow code 0 (sequential) advances the counter by 4.
- R4: Flow code 1 (branch-if-equal) sets the counter to PC+4+(sign-extended offset × 4) when `opnd_a` equals `opnd_b`, and to PC+4 otherwise.
- R5: Flow code 2 (branch-if-not-equal) sets the counter to PC+4+(sign-extended offset × 4) when `opnd_a` differs from `opnd_b`, and to PC+4 otherwise.
- R6: Flow code 3 (jump) sets the counter to {PC[31:28], field, 2'b00}. The top four bits come from the current PC and not from PC+4, so a jump from 0x0FFF_FFFC stays in region 0.
- R7: Flow code 4 (jump with link) moves the counter exactly as R6 does. In the next cycle `link_we_o` is high for that one cycle only, with `link_val_o` equal to the old PC+4 and `link_reg_o` equal to 31. No other class raises `link_we_o`.
- R8: Flow code 5 (jump via register) loads `reg_target` into the counter unchanged.
- R9: `taken_o` is high in the cycle after an advance that redirected the flow (a branch that was taken, a jump, a jump with link, a jump via register). It is low after sequential steps and after branches that were not taken.
- R10: The unused flow codes 6 and 7 behave as sequential: the counter advances by 4, with no link and no taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; the counter moves only when high |
| flow_sel | input | 3 | Decoded flow class (codes in R3 to R10) |
| br_offset | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word-address field of absolute jumps |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| reg_target | input | 32 | Register value for jump via register |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | One-cycle request to write the link register |
| link_reg_o | output | 5 | Index of the link register (31) |
| link_val_o | output | 32 | Return address to be written |
| taken_o | output | 1 | Previous advance redirected the flow |

## Verification
Two things can land on one edge. A jump with link both redirects the counter and raises the link request, and reset can arrive while the advance enable and a jump-with-link class are both present. The bench drives a jump with link and checks, one cycle later, the new counter, the link value and the taken flag together. It then checks the cycle after that to make sure the link request has dropped. It also holds reset high with a jump-with-link class and the enable asserted, and expects the start address with both link and taken low, which shows that reset wins.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

    // Decoded flow classes; codes 6 and 7 are unused and fall through.
    typedef enum logic [2:0] {
        FL_SEQ  = 3'd0,
        FL_BEQ  = 3'd1,
        FL_BNE  = 3'd2,
        FL_JMP  = 3'd3,
        FL_JAL  = 3'd4,
        FL_JREG = 3'd5
    } flow_e;

    localparam int unsigned FLOW_W = 3;

endpackage

// File: rtl/npc_compare.sv
`timescale 1ns/1ps
// Decides whether a conditional branch is taken.
module npc_compare #(
    parameter int unsigned XLEN = 32
) (
    input  logic [npc_pkg::FLOW_W-1:0] flow_sel,
    input  logic [XLEN-1:0]            opnd_a,
    input  logic [XLEN-1:0]            opnd_b,
    output logic                       is_branch,
    output logic                       cond_met
);
    import npc_pkg::*;

    logic same;

    always_comb begin
        same      = (opnd_a == opnd_b);
        is_branch = 1'b0;
        cond_met  = 1'b0;
        case (flow_sel)
            FL_BEQ: begin
                is_branch = 1'b1;
                cond_met  = same;
            end
            FL_BNE: begin
                is_branch = 1'b1;
                cond_met  = !same;
            end
            default: begin
                is_branch = 1'b0;
                cond_met  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/npc_targets.sv
`timescale 1ns/1ps
// Forms the sequential, branch and absolute jump target addresses.
module npc_targets #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned JF_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [JF_W-1:0]  jmp_field,
    output logic [XLEN-1:0]  seq_tgt,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    localparam int unsigned EXT_W    = XLEN - OFF_W - 2;
    localparam int unsigned REGION_W = XLEN - JF_W - 2;

    logic [XLEN-1:0] disp;

    always_comb begin
        seq_tgt = pc + XLEN'(4);
        disp    = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 2'b00};
        br_tgt  = seq_tgt + disp;
        jmp_tgt = {pc[XLEN-1 -: REGION_W], jmp_field, 2'b00};
    end

endmodule

// File: rtl/npc_select.sv
`timescale 1ns/1ps
// Picks the next counter value and the side effects for the flow class.
module npc_select #(
    parameter int unsigned XLEN = 32
) (
    input  logic [npc_pkg::FLOW_W-1:0] flow_sel,
    input  logic                       is_branch,
    input  logic                       cond_met,
    input  logic [XLEN-1:0]            seq_tgt,
    input  logic [XLEN-1:0]            br_tgt,
    input  logic [XLEN-1:0]            jmp_tgt,
    input  logic [XLEN-1:0]            reg_target,
    output logic [XLEN-1:0]            next_pc,
    output logic                       redirect,
    output logic                       want_link
);
    import npc_pkg::*;

    always_comb begin
        next_pc   = seq_tgt;
        redirect  = 1'b0;
        want_link = 1'b0;
        if (is_branch) begin
            if (cond_met) begin
                next_pc  = br_tgt;
                redirect = 1'b1;
            end
        end else begin
            case (flow_sel)
                FL_JMP: begin
                    next_pc  = jmp_tgt;
                    redirect = 1'b1;
                end
                FL_JAL: begin
                    next_pc   = jmp_tgt;
                    redirect  = 1'b1;
                    want_link = 1'b1;
                end
                FL_JREG: begin
                    next_pc  = reg_target;
                    redirect = 1'b1;
                end
                default: begin
                    next_pc  = seq_tgt;
                    redirect = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
// Program counter register and next-address selection.
module npc_unit #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned JF_W       = 26,
    parameter int unsigned RIDX_W     = 5,
    parameter int unsigned LINK_REG   = 31,
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv_en,
    input  logic [npc_pkg::FLOW_W-1:0] flow_sel,
    input  logic [OFF_W-1:0]           br_offset,
    input  logic [JF_W-1:0]            jmp_field,
    input  logic [XLEN-1:0]            opnd_a,
    input  logic [XLEN-1:0]            opnd_b,
    input  logic [XLEN-1:0]            reg_target,
    output logic [XLEN-1:0]            pc_o,
    output logic                       link_we_o,
    output logic [RIDX_W-1:0]          link_reg_o,
    output logic [XLEN-1:0]            link_val_o,
    output logic                       taken_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            link_we;
        logic [XLEN-1:0] link_val;
        logic            taken;
    } npc_state_t;

    npc_state_t st_d, st_q;

    logic            is_branch, cond_met;
    logic [XLEN-1:0] seq_tgt, br_tgt, jmp_tgt, next_pc;
    logic            redirect, want_link;

    npc_compare #(.XLEN(XLEN)) u_cmp (
        .flow_sel  (flow_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .is_branch (is_branch),
        .cond_met  (cond_met)
    );

    npc_targets #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
        .pc        (st_q.pc),
        .br_offset (br_offset),
        .jmp_field (jmp_field),
        .seq_tgt   (seq_tgt),
        .br_tgt    (br_tgt),
        .jmp_tgt   (jmp_tgt)
    );

    npc_select #(.XLEN(XLEN)) u_sel (
        .flow_sel   (flow_sel),
        .is_branch  (is_branch),
        .cond_met   (cond_met),
        .seq_tgt    (seq_tgt),
        .br_tgt     (br_tgt),
        .jmp_tgt    (jmp_tgt),
        .reg_target (reg_target),
        .next_pc    (next_pc),
        .redirect   (redirect),
        .want_link  (want_link)
    );

    always_comb begin
        st_d          = st_q;
        st_d.link_we  = 1'b0;
        st_d.taken    = 1'b0;
        if (rst) begin
            st_d.pc       = XLEN'(START_ADDR);
            st_d.link_val = '0;
        end else if (adv_en) begin
            st_d.pc      = next_pc;
            st_d.taken   = redirect;
            st_d.link_we = want_link;
            if (want_link) begin
                st_d.link_val = seq_tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign link_we_o  = st_q.link_we;
    assign link_val_o = st_q.link_val;
    assign link_reg_o = RIDX_W'(LINK_REG);
    assign taken_o    = st_q.taken;

endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned OFF_W      = 16,
    parameter int unsigned JF_W       = 26,
    parameter int unsigned RIDX_W     = 5,
    parameter int unsigned LINK_REG   = 31,
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       adv_en,
    input logic [npc_pkg::FLOW_W-1:0] flow_sel,
    input logic [OFF_W-1:0]           br_offset,
    input logic [JF_W-1:0]            jmp_field,
    input logic [XLEN-1:0]            opnd_a,
    input logic [XLEN-1:0]            opnd_b,
    input logic [XLEN-1:0]            reg_target,
    input logic [XLEN-1:0]            pc_o,
    input logic                       link_we_o,
    input logic [RIDX_W-1:0]          link_reg_o,
    input logic [XLEN-1:0]            link_val_o,
    input logic                       taken_o
);
    import npc_pkg::*;

    // R1
    reset_load_chk: assert property (@(posedge clk)
        rst |=> (pc_o == XLEN'(START_ADDR) && !link_we_o && !taken_o));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> ($stable(pc_o) && !link_we_o && !taken_o));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_sel == FL_SEQ) |=> (pc_o == $past(pc_o) + XLEN'(4)));

    // R4
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_sel == FL_BEQ && opnd_a != opnd_b)
        |=> (pc_o == $past(pc_o) + XLEN'(4) && !taken_o));

    // R5
    bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_sel == FL_BNE && opnd_a == opnd_b)
        |=> (pc_o == $past(pc_o) + XLEN'(4) && !taken_o));

    // R7
    link_src_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> ($past(adv_en) && $past(flow_sel) == FL_JAL
                       && link_val_o == $past(pc_o) + XLEN'(4)
                       && link_reg_o == RIDX_W'(LINK_REG)));

    // R8
    jreg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && flow_sel == FL_JREG) |=> (pc_o == $past(reg_target) && taken_o));

    // R9
    taken_src_chk: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> ($past(adv_en) && $past(flow_sel) != FL_SEQ));

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W), .RIDX_W(RIDX_W),
    .LINK_REG(LINK_REG), .START_ADDR(START_ADDR)
) u_chk (.*);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
    import npc_pkg::*;

    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_en = 1'b0;
    logic [2:0]  flow_sel = 3'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, reg_target = '0;
    logic [31:0] pc_o, link_val_o;
    logic        link_we_o, taken_o;
    logic [4:0]  link_reg_o;

    always #10 clk = ~clk;   // 50 MHz

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .adv_en(adv_en), .flow_sel(flow_sel),
        .br_offset(br_offset), .jmp_field(jmp_field),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_target(reg_target),
        .pc_o(pc_o), .link_we_o(link_we_o), .link_reg_o(link_reg_o),
        .link_val_o(link_val_o), .taken_o(taken_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        lwe;
        logic [31:0] lval;
        logic        tkn;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] mpc;
    bit          done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expectation per edge, samples 5 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "pc", pc_o, e.pc);
                chk(e.tag, "link_we", {31'd0, link_we_o}, {31'd0, e.lwe});
                chk(e.tag, "taken", {31'd0, taken_o}, {31'd0, e.tkn});
                if (e.lwe) begin
                    chk(e.tag, "link_val", link_val_o, e.lval);
                    chk(e.tag, "link_reg", {27'd0, link_reg_o}, 32'd31);
                end
            end
        end
    end

    // Driver: sets inputs at the falling edge and queues the expected result.
    task automatic step(string tag, bit adv, logic [2:0] f, logic [15:0] off,
                        logic [25:0] jf, logic [31:0] a, logic [31:0] b,
                        logic [31:0] r);
        exp_t e;
        logic [31:0] seq, btgt, jtgt;
        @(negedge clk);
        rst = 1'b0; adv_en = adv; flow_sel = f; br_offset = off;
        jmp_field = jf; opnd_a = a; opnd_b = b; reg_target = r;
        seq  = mpc + 32'd4;
        btgt = seq + {{14{off[15]}}, off, 2'b00};
        jtgt = {mpc[31:28], jf, 2'b00};
        e.tag = tag; e.lwe = 1'b0; e.lval = 32'd0; e.tkn = 1'b0; e.pc = mpc;
        if (adv) begin
            case (f)
                3'd1: begin e.pc = (a == b) ? btgt : seq; e.tkn = (a == b); end
                3'd2: begin e.pc = (a != b) ? btgt : seq; e.tkn = (a != b); end
                3'd3: begin e.pc = jtgt; e.tkn = 1'b1; end
                3'd4: begin e.pc = jtgt; e.tkn = 1'b1; e.lwe = 1'b1; e.lval = seq; end
                3'd5: begin e.pc = r; e.tkn = 1'b1; end
                default: e.pc = seq;
            endcase
        end
        mpc = e.pc;
        sb.push_back(e);
    endtask

    task automatic do_reset(bit adv);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; adv_en = adv; flow_sel = FL_JAL; jmp_field = 26'h155_5555;
        e.tag = "R1"; e.pc = START; e.lwe = 1'b0; e.lval = 32'd0; e.tkn = 1'b0;
        mpc = START;
        sb.push_back(e);
    endtask

    initial begin
        mpc = START;
        do_reset(1'b0);
        step("R3",  1, FL_SEQ, 16'h0, 26'h0, 32'd0, 32'd0, 32'd0);
        step("R3",  1, FL_SEQ, 16'h7, 26'h3, 32'd1, 32'd2, 32'd9);
        step("R4",  1, FL_BEQ, 16'h0010, 26'h0, 32'hABCD, 32'hABCD, 32'd0);
        step("R4",  1, FL_BEQ, 16'h0010, 26'h0, 32'hABCD, 32'hABCE, 32'd0);
        step("R5",  1, FL_BNE, 16'hFFFE, 26'h0, 32'd5, 32'd6, 32'd0);
        step("R5",  1, FL_BNE, 16'hFFFE, 26'h0, 32'd7, 32'd7, 32'd0);
        step("R4",  1, FL_BEQ, 16'h8000, 26'h0, 32'd3, 32'd3, 32'd0);
        step("R4",  1, FL_BEQ, 16'h7FFF, 26'h0, 32'd0, 32'd0, 32'd0);
        step("R2",  0, FL_JMP, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, 32'd0);
        step("R2",  0, FL_JAL, 16'h0, 26'h12_3456, 32'd0, 32'd0, 32'd0);
        step("R8",  1, FL_JREG, 16'h0, 26'h0, 32'd0, 32'd0, 32'hA000_1000);
        step("R6",  1, FL_JMP, 16'h0, 26'h000_0040, 32'd0, 32'd0, 32'd0);
        step("R8",  1, FL_JREG, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0FFF_FFFC);
        step("R6",  1, FL_JMP, 16'h0, 26'h000_0100, 32'd0, 32'd0, 32'd0);
        step("R8",  1, FL_JREG, 16'h0, 26'h0, 32'd0, 32'd0, 32'h7000_0020);
        step("R7",  1, FL_JAL, 16'h0, 26'h0AB_CDE0, 32'd0, 32'd0, 32'd0);
        step("R7",  1, FL_SEQ, 16'h0, 26'h0, 32'd0, 32'd0, 32'd0);
        step("R7",  1, FL_JAL, 16'h0, 26'h000_0010, 32'd0, 32'd0, 32'd0);
        step("R7",  0, FL_JAL, 16'h0, 26'h000_0010, 32'd0, 32'd0, 32'd0);
        step("R10", 1, 3'd6, 16'h0044, 26'h3FF_FFFF, 32'd1, 32'd1, 32'hFFFF_FFF0);
        step("R10", 1, 3'd7, 16'h0044, 26'h3FF_FFFF, 32'd1, 32'd1, 32'hFFFF_FFF0);
        step("R9",  1, FL_BNE, 16'h0000, 26'h0, 32'd1, 32'd2, 32'd0);
        do_reset(1'b1);
        step("R1",  1, FL_SEQ, 16'h0, 26'h0, 32'd0, 32'd0, 32'd0);
        step("R5",  1, FL_BNE, 16'hFFFF, 26'h0, 32'h8000_0000, 32'h0, 32'd0);
        @(negedge clk);
        adv_en = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover=%0d expected=0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule